// File: doc/BRIEF.md
# Event Timer Global Register File and Main Counter

This block is the shared front end of a multi-channel event timer. It sits on a 32-bit register bus and owns the state that all channels share: a read-only capability word pair, a two-bit configuration register (global run and legacy routing), a per-channel interrupt status register and a free-running 64-bit main counter. The counter advances by one on every `tick` while the global run bit is set. Clearing the run bit freezes the counter where it is, and setting the run bit again resumes counting from that value.

Bus addresses from 0x100 to 0x3FF form one 32-byte window per channel. The block decodes them and hands them to the channels. Reads are routed combinationally to the channel read port. Writes are passed on as a registered one-cycle strobe carrying the channel index, the in-window offset and the data. Windows beyond the implemented channel count read as zero, and writes to them are discarded.

When the run bit rises, the block emits a one-cycle arm pulse with a mask of the channels that hold a programmed comparator. When the run bit falls, it emits a disarm pulse. Channels raise status bits through `ch_irq_set`, and software clears them by writing ones to the status register. Each cleared bit also produces a one-cycle clear pulse back to its channel, so the channel can drop its level interrupt.

Top module: `evt_gblk`

## Requirements
- R1: After reset the main counter, the configuration and the status register are all zero, `glb_en`, `legacy_en` and `bus_rvalid` are low, and no strobe or pulse output is active.
- R2: Offset 0x000 reads the capability low word: bits [7:0] revision, [12:8] channel count minus one, bit 13 set (64-bit counter), bit 14 zero, bit 15 set (legacy routing capable), [31:16] vendor code. Offset 0x004 reads the tick period in femtoseconds. Writes to both offsets have no effect on what they read.
- R3: Offset 0x010 holds the configuration: bit 0 is global run (drives `glb_en`) and bit 1 is legacy routing (drives `legacy_en`). All other bits read 0. Offset 0x014 always reads 0 and ignores writes.
- R4: While the run bit is set, the counter increases by one at each clock edge where `tick` is high. While the run bit is clear the counter holds its value, and re-enabling resumes from it. The count carries from the low half into the high half.
- R5: Offset 0x0F0 writes the low 32 bits of the counter and 0x0F4 writes the high 32 bits, at any time. A counter write replaces that edge's increment. A counter write made while running raises `cnt_warn` for one cycle.
- R6: A write that takes the run bit from 0 to 1 gives a one-cycle `arm_stb` in the next cycle, with `arm_mask` bit i set when `ch_cmp_ones[i]` is low. A write that takes the run bit from 1 to 0 gives a one-cycle `disarm_stb`. The two pulses never coincide.
- R7: A `ch_irq_set` bit sets its status bit (offset 0x020, bit i for channel i). Writing 1 to a set bit clears it and pulses `ch_irq_clr[i]` for one cycle in the next cycle. If a set and a clear of the same bit happen on the same edge, the set wins and no clear pulse is issued for that bit.
- R8: A write to a valid channel window gives a one-cycle `ch_wr_stb` in the next cycle with `ch_wr_idx` = (address − 0x100) / 32, `ch_wr_off` = address bits [4:2] followed by two zero bits, and `ch_wr_data` = the written data.
- R9: A read of a valid channel window returns `ch_rdata`, sampled with `ch_rd_idx`/`ch_rd_off` decoded as in R8. Windows with index ≥ the channel count, and all unmapped global offsets, read 0, and writes to them produce no strobe.
- R10: `bus_rvalid` is high in exactly the cycle after a read request, and `bus_rdata` holds that read's data during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ch_rd_idx | output | TIDX_W | Channel index of the current window read |
| ch_rd_off | output | 5 | Offset inside the window for the read |
| ch_rdata | input | 32 | Read data from the addressed channel |
| ch_wr_stb | output | 1 | Channel write strobe |
| ch_wr_idx | output | TIDX_W | Channel index of the write |
| ch_wr_off | output | 5 | Offset inside the window for the write |
| ch_wr_data | output | 32 | Channel write data |
| ch_cmp_ones | input | NUM_TMR | Channel comparator is all ones |
| arm_stb | output | 1 | Arm pulse on run-bit rise |
| arm_mask | output | NUM_TMR | Channels to arm |
| disarm_stb | output | 1 | Disarm pulse on run-bit fall |
| ch_irq_set | input | NUM_TMR | Channel interrupt events |
| ch_irq_clr | output | NUM_TMR | Interrupt clear pulses |
| glb_en | output | 1 | Global run bit |
| legacy_en | output | 1 | Legacy routing bit |
| main_cnt | output | 64 | Main counter value |
| cnt_warn | output | 1 | Counter written while running |

## Verification
Every result of a bus access arrives exactly one clock after the edge that takes the request. Read data and `bus_rvalid`, the channel write strobe, the arm and disarm pulses, the interrupt clear pulses and `cnt_warn` all come from one register stage. The bench drives each access on a falling edge and samples on the next falling edge, so it reads these results in the one cycle they are valid. It then confirms that the pulses have dropped one cycle later. Counter checks count edges: with the run bit written on edge A and cleared on edge A+n, exactly n increments are expected, because the clearing edge still counts and the enabling edge does not.

// File: rtl/evt_gblk_pkg.sv
package evt_gblk_pkg;
  localparam logic [11:0] OFS_CAP_LO = 12'h000;
  localparam logic [11:0] OFS_CAP_HI = 12'h004;
  localparam logic [11:0] OFS_CFG    = 12'h010;
  localparam logic [11:0] OFS_CFG_HI = 12'h014;
  localparam logic [11:0] OFS_STAT   = 12'h020;
  localparam logic [11:0] OFS_CNT_LO = 12'h0F0;
  localparam logic [11:0] OFS_CNT_HI = 12'h0F4;

  typedef struct packed {
    logic leg;
    logic run;
  } cfg_t;

  // capability low word; channel count minus one sits in bits 12:8
  function automatic logic [31:0] cap_word(input logic [15:0] vendor,
                                           input logic [7:0]  rev,
                                           input logic [4:0]  cnt_m1);
    return {vendor, 1'b1, 1'b0, 1'b1, cnt_m1, rev};
  endfunction
endpackage

// File: rtl/evt_win_dec.sv
module evt_win_dec #(
  parameter int ADDR_W  = 12,
  parameter int NUM_TMR = 3,
  parameter int TIDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [TIDX_W-1:0] idx,
  output logic [4:0]        off
);
  logic [4:0] raw_idx;
  logic       in_rng;
  logic       unused_lo;

  assign unused_lo = ^addr[1:0];

  always_comb begin
    in_rng  = (addr[ADDR_W-1:10] == '0) && (addr[9:8] != 2'b00);
    raw_idx = addr[9:5] - 5'd8;
    hit     = in_rng && ({27'd0, raw_idx} < 32'(NUM_TMR));
    idx     = raw_idx[TIDX_W-1:0];
    off     = {addr[4:2], 2'b00};
  end
endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cnt
);
  logic [63:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)            cnt_d = {cnt_q[63:32], wdata};
    else if (wr_hi)       cnt_d = {wdata, cnt_q[31:0]};
    else if (run && tick) cnt_d = cnt_q + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/evt_stat_reg.sv
module evt_stat_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] stat,
  output logic [N-1:0] clr_pulse
);
  logic [N-1:0] stat_q, stat_d, pulse_q, pulse_d, kill;

  always_comb begin
    kill    = clr_en ? (clr_bits & stat_q & ~set) : '0;
    stat_d  = (stat_q & ~kill) | set;
    pulse_d = kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      pulse_q <= '0;
    end else begin
      stat_q  <= stat_d;
      pulse_q <= pulse_d;
    end
  end

  assign stat      = stat_q;
  assign clr_pulse = pulse_q;
endmodule

// File: rtl/evt_gblk.sv
module evt_gblk #(
  parameter int          ADDR_W  = 12,
  parameter int          NUM_TMR = 3,
  parameter logic [15:0] VENDOR  = 16'hCAFE,
  parameter logic [7:0]  REV     = 8'h02,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  localparam int         TIDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic [TIDX_W-1:0]  ch_rd_idx,
  output logic [4:0]         ch_rd_off,
  input  logic [31:0]        ch_rdata,
  output logic               ch_wr_stb,
  output logic [TIDX_W-1:0]  ch_wr_idx,
  output logic [4:0]         ch_wr_off,
  output logic [31:0]        ch_wr_data,
  input  logic [NUM_TMR-1:0] ch_cmp_ones,
  output logic               arm_stb,
  output logic [NUM_TMR-1:0] arm_mask,
  output logic               disarm_stb,
  input  logic [NUM_TMR-1:0] ch_irq_set,
  output logic [NUM_TMR-1:0] ch_irq_clr,
  output logic               glb_en,
  output logic               legacy_en,
  output logic [63:0]        main_cnt,
  output logic               cnt_warn
);
  import evt_gblk_pkg::*;

  localparam logic [31:0] CAP_LO = cap_word(VENDOR, REV, 5'(NUM_TMR - 1));

  logic [ADDR_W-1:0] wa;
  logic              rd_req, wr_req, win_hit;
  logic              wr_cfg, wr_stat, wr_cnt_lo, wr_cnt_hi;
  logic [TIDX_W-1:0] win_idx;
  logic [4:0]        win_off;
  cfg_t              cfg_q, cfg_d;
  logic [NUM_TMR-1:0] stat;
  logic [31:0]       stat_ext, rd_mux, rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  logic              stb_q, stb_d, arm_q, arm_d, dis_q, dis_d, warn_q, warn_d;
  logic [NUM_TMR-1:0] mask_q, mask_d;
  logic [TIDX_W-1:0] widx_q, widx_d;
  logic [4:0]        woff_q, woff_d;
  logic [31:0]       wdat_q, wdat_d;

  evt_win_dec #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR), .TIDX_W(TIDX_W)) u_dec (
    .addr(bus_addr), .hit(win_hit), .idx(win_idx), .off(win_off)
  );

  evt_main_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .tick(tick),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(bus_wdata), .cnt(main_cnt)
  );

  evt_stat_reg #(.N(NUM_TMR)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(ch_irq_set), .clr_en(wr_stat),
    .clr_bits(bus_wdata[NUM_TMR-1:0]), .stat(stat), .clr_pulse(ch_irq_clr)
  );

  // request decode
  always_comb begin
    wa        = {bus_addr[ADDR_W-1:2], 2'b00};
    rd_req    = bus_sel && !bus_wr;
    wr_req    = bus_sel && bus_wr;
    wr_cfg    = wr_req && (wa == ADDR_W'(OFS_CFG));
    wr_stat   = wr_req && (wa == ADDR_W'(OFS_STAT));
    wr_cnt_lo = wr_req && (wa == ADDR_W'(OFS_CNT_LO));
    wr_cnt_hi = wr_req && (wa == ADDR_W'(OFS_CNT_HI));
  end

  // read path
  always_comb begin
    stat_ext              = '0;
    stat_ext[NUM_TMR-1:0] = stat;
    rd_mux                = '0;
    if (win_hit) rd_mux = ch_rdata;
    else if (wa == ADDR_W'(OFS_CAP_LO)) rd_mux = CAP_LO;
    else if (wa == ADDR_W'(OFS_CAP_HI)) rd_mux = TICK_FS;
    else if (wa == ADDR_W'(OFS_CFG))    rd_mux = {30'd0, cfg_q};
    else if (wa == ADDR_W'(OFS_STAT))   rd_mux = stat_ext;
    else if (wa == ADDR_W'(OFS_CNT_LO)) rd_mux = main_cnt[31:0];
    else if (wa == ADDR_W'(OFS_CNT_HI)) rd_mux = main_cnt[63:32];
    rdata_d  = rd_req ? rd_mux : '0;
    rvalid_d = rd_req;
  end

  // configuration, arm/disarm, channel write forwarding
  always_comb begin
    cfg_d  = cfg_q;
    if (wr_cfg) cfg_d = cfg_t'(bus_wdata[1:0]);
    arm_d  = wr_cfg && !cfg_q.run && bus_wdata[0];
    dis_d  = wr_cfg && cfg_q.run && !bus_wdata[0];
    mask_d = arm_d ? ~ch_cmp_ones : '0;
    warn_d = (wr_cnt_lo || wr_cnt_hi) && cfg_q.run;
    stb_d  = wr_req && win_hit;
    widx_d = stb_d ? win_idx : widx_q;
    woff_d = stb_d ? win_off : woff_q;
    wdat_d = stb_d ? bus_wdata : wdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      arm_q    <= 1'b0;
      dis_q    <= 1'b0;
      mask_q   <= '0;
      warn_q   <= 1'b0;
      stb_q    <= 1'b0;
      widx_q   <= '0;
      woff_q   <= '0;
      wdat_q   <= '0;
    end else begin
      cfg_q    <= cfg_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      arm_q    <= arm_d;
      dis_q    <= dis_d;
      mask_q   <= mask_d;
      warn_q   <= warn_d;
      stb_q    <= stb_d;
      widx_q   <= widx_d;
      woff_q   <= woff_d;
      wdat_q   <= wdat_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign ch_rd_idx  = win_idx;
  assign ch_rd_off  = win_off;
  assign ch_wr_stb  = stb_q;
  assign ch_wr_idx  = widx_q;
  assign ch_wr_off  = woff_q;
  assign ch_wr_data = wdat_q;
  assign arm_stb    = arm_q;
  assign arm_mask   = mask_q;
  assign disarm_stb = dis_q;
  assign glb_en     = cfg_q.run;
  assign legacy_en  = cfg_q.leg;
  assign cnt_warn   = warn_q;
endmodule

// File: rtl/evt_gblk_chk.sv
module evt_gblk_chk #(
  parameter int ADDR_W  = 12,
  parameter int NUM_TMR = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rvalid,
  input logic               ch_wr_stb,
  input logic               arm_stb,
  input logic               disarm_stb,
  input logic [NUM_TMR-1:0] ch_irq_clr,
  input logic               glb_en,
  input logic [63:0]        main_cnt,
  input logic               cnt_warn
);
  logic [ADDR_W-1:0] wa;
  logic              cnt_touch, stat_wr, rd_req;

  assign wa        = {bus_addr[ADDR_W-1:2], 2'b00};
  assign cnt_touch = bus_sel && bus_wr && ((wa == ADDR_W'(12'h0F0)) || (wa == ADDR_W'(12'h0F4)));
  assign stat_wr   = bus_sel && bus_wr && (wa == ADDR_W'(12'h020));
  assign rd_req    = bus_sel && !bus_wr;

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!glb_en && !cnt_touch) |-> main_cnt == $past(main_cnt));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(glb_en && tick && !cnt_touch) |-> main_cnt == $past(main_cnt) + 64'd1);
  p_warn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_warn |-> $past(glb_en && cnt_touch));
  p_arm_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_stb && disarm_stb));
  p_arm_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_stb |-> glb_en && !$past(glb_en));
  p_clr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq_clr != '0) |-> $past(stat_wr));
  p_stb_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_stb |-> $past(bus_sel && bus_wr));
  p_rv_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  p_rv_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

bind evt_gblk evt_gblk_chk #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR)) u_chk (.*);

// File: tb/sim_evt_gblk.sv
module sim_evt_gblk;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ch_rdata, ch_wr_data;
  logic        bus_rvalid, ch_wr_stb, arm_stb, disarm_stb, glb_en, legacy_en, cnt_warn;
  logic [1:0]  ch_rd_idx, ch_wr_idx;
  logic [4:0]  ch_rd_off, ch_wr_off;
  logic [N-1:0] ch_cmp_ones = '0, ch_irq_set = '0, arm_mask, ch_irq_clr;
  logic [63:0] main_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // channel model: read data encodes the decoded index and offset
  assign ch_rdata = {16'hA500, 3'b000, ch_rd_off, 6'b000000, ch_rd_idx};

  evt_gblk u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    check("R10 rvalid", 64'(bus_rvalid), 64'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] win_exp(input int a);
    int idx;
    idx = (a - 256) / 32;
    if (idx < N) return {16'hA500, 3'b000, 3'(a[4:2]), 2'b00, 6'b000000, 2'(idx)};
    return 32'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cap;
    cap = {16'hCAFE, 1'b1, 1'b0, 1'b1, 5'(N - 1), 8'h02};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cnt", main_cnt, 64'd0);
    check("R1 glb_en", 64'(glb_en), 64'd0);
    check("R1 legacy", 64'(legacy_en), 64'd0);
    check("R1 rvalid", 64'(bus_rvalid), 64'd0);
    check("R1 strobes", 64'({ch_wr_stb, arm_stb, disarm_stb, cnt_warn, ch_irq_clr}), 64'd0);
    brd(12'h010, d); check("R1 cfg", 64'(d), 64'd0);
    brd(12'h020, d); check("R1 stat", 64'(d), 64'd0);
    idle(1); check("R10 rvalid drops", 64'(bus_rvalid), 64'd0);

    // R5 counter halves while stopped
    bwr(12'h0F0, 32'd100); check("R5 no warn when stopped", 64'(cnt_warn), 64'd0);
    bwr(12'h0F4, 32'd0);
    brd(12'h0F0, d); check("R5 lo", 64'(d), 64'd100);
    brd(12'h0F4, d); check("R5 hi", 64'(d), 64'd0);

    // R6 arm pulse, R4 ten increments
    ch_cmp_ones = 3'b010;
    bwr(12'h010, 32'd1);
    check("R6 arm", 64'(arm_stb), 64'd1);
    check("R6 mask", 64'(arm_mask), 64'(3'b101));
    check("R3 glb_en", 64'(glb_en), 64'd1);
    idle(1); check("R6 arm one cycle", 64'(arm_stb), 64'd0);
    idle(8);
    bwr(12'h010, 32'd0);
    check("R6 disarm", 64'(disarm_stb), 64'd1);
    check("R6 no arm", 64'(arm_stb), 64'd0);
    brd(12'h0F0, d); check("R4 count", 64'(d), 64'd110);
    check("R6 disarm one cycle", 64'(disarm_stb), 64'd0);
    idle(5);
    brd(12'h0F0, d); check("R4 frozen", 64'(d), 64'd110);

    // R4 resume
    bwr(12'h010, 32'd1); idle(4); bwr(12'h010, 32'd0);
    brd(12'h0F0, d); check("R4 resume", 64'(d), 64'd115);

    // R4 tick gating
    tick = 1'b0;
    bwr(12'h010, 32'd1); idle(9); bwr(12'h010, 32'd0);
    tick = 1'b1;
    brd(12'h0F0, d); check("R4 tick low", 64'(d), 64'd115);

    // R4 carry into high half
    bwr(12'h0F0, 32'hFFFF_FFFF); bwr(12'h0F4, 32'd7);
    bwr(12'h010, 32'd1); bwr(12'h010, 32'd0);
    brd(12'h0F4, d); check("R4 carry hi", 64'(d), 64'd8);
    brd(12'h0F0, d); check("R4 carry lo", 64'(d), 64'd0);
    check("R4 main_cnt", main_cnt, 64'h8_0000_0000);

    // R5 write while running
    bwr(12'h010, 32'd1);
    bwr(12'h0F0, 32'd500);
    check("R5 warn", 64'(cnt_warn), 64'd1);
    bwr(12'h010, 32'd0);
    check("R5 warn one cycle", 64'(cnt_warn), 64'd0);
    brd(12'h0F0, d); check("R5 write beats increment", 64'(d), 64'd501);

    // R3 configuration
    bwr(12'h010, 32'hFFFF_FFFE);
    brd(12'h010, d); check("R3 cfg mask", 64'(d), 64'd2);
    check("R3 legacy", 64'(legacy_en), 64'd1);
    check("R3 run clear", 64'(glb_en), 64'd0);
    bwr(12'h014, 32'hFFFF_FFFF);
    brd(12'h014, d); check("R3 cfg hi", 64'(d), 64'd0);
    brd(12'h010, d); check("R3 cfg kept", 64'(d), 64'd2);
    bwr(12'h010, 32'd0);
    check("R3 legacy off", 64'(legacy_en), 64'd0);

    // R2 capability
    brd(12'h000, d); check("R2 cap lo", 64'(d), 64'(cap));
    brd(12'h004, d); check("R2 cap hi", 64'(d), 64'd10_000_000);
    bwr(12'h000, 32'd0); bwr(12'h004, 32'd0);
    brd(12'h000, d); check("R2 cap lo ro", 64'(d), 64'(cap));
    brd(12'h004, d); check("R2 cap hi ro", 64'(d), 64'd10_000_000);

    // R7 status
    ch_irq_set = 3'b111; @(negedge clk); ch_irq_set = '0;
    brd(12'h020, d); check("R7 set", 64'(d), 64'd7);
    bwr(12'h020, 32'h0000_0005);
    check("R7 clr pulse", 64'(ch_irq_clr), 64'd5);
    brd(12'h020, d); check("R7 w1c", 64'(d), 64'd2);
    check("R7 pulse one cycle", 64'(ch_irq_clr), 64'd0);
    bwr(12'h020, 32'h0000_0005);
    check("R7 clr of clear bits", 64'(ch_irq_clr), 64'd0);
    ch_irq_set = 3'b001;
    bwr(12'h020, 32'h0000_0001);
    ch_irq_set = '0;
    check("R7 set wins pulse", 64'(ch_irq_clr), 64'd0);
    brd(12'h020, d); check("R7 set wins", 64'(d), 64'd3);

    // R8/R9 sweep of every channel window word
    for (int a = 256; a < 1024; a += 4) begin
      brd(12'(a), d);
      check("R9 window read", 64'(d), 64'(win_exp(a)));
      bwr(12'(a), 32'(a) ^ 32'h5000_0000);
      if ((a - 256) / 32 < N) begin
        check("R8 stb", 64'(ch_wr_stb), 64'd1);
        check("R8 fields", 64'({ch_wr_idx, ch_wr_off, ch_wr_data}),
              64'({2'((a - 256) / 32), 3'(a[4:2]), 2'b00, 32'(a) ^ 32'h5000_0000}));
      end else begin
        check("R9 write dropped", 64'(ch_wr_stb), 64'd0);
      end
    end
    idle(1); check("R8 one cycle", 64'(ch_wr_stb), 64'd0);

    // R9 unmapped offsets
    brd(12'h008, d); check("R9 unmapped 008", 64'(d), 64'd0);
    brd(12'h030, d); check("R9 unmapped 030", 64'(d), 64'd0);
    brd(12'h400, d); check("R9 unmapped 400", 64'(d), 64'd0);
    brd(12'h900, d); check("R9 unmapped 900", 64'(d), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule